// File: doc/BRIEF.md
# Hub Execution Line Fetch Controller

This block lets a processor core run instructions straight out of shared hub memory. It holds the core's widened program counter. Each fetch goes either to the core's local instruction memory or to an eight-long line buffer that is filled from the hub. Counter values below a fixed boundary address local memory. Values at or above that boundary are hub code.

A jump into hub code reloads the line buffer only when the target line is not already held. Execution then starts at the long that the target's low bits select. When the counter steps past the last long of the line, the following line is requested without any software help. The core is stalled while a fill is in progress, because the buffer's write path is shared with the hub.

Any cached hub access made by another operation invalidates the line, so the next hub fetch reloads it. The line buffer can also be read through a fixed register window.

Top module: `hubx_fetch_ctrl`

## Requirements
- R1: After reset, `pc` is 0, `stall` is 0 and `hub_req` is 0.
- R2: While `pc` < 0x800, `loc_addr` equals the low 11 bits of `pc`, `instr` equals `loc_instr`, `instr_valid` is 1, `stall` is 0, and no hub request is raised.
- R3: When `pc` ≥ 0x800 and its line (`pc` with the low 3 bits dropped) is not held, a request is raised with `hub_addr` = {line, 5'b0}. This is a byte address: the two implied zero bits plus the three index bits. The 8 returned beats are written to buffer entries 0 to 7, in order of arrival.
- R4: `hub_req` stays high, with `hub_addr` unchanged, until `hub_gnt` is seen.
- R5: After a fill, `instr` equals the long at index `pc[2:0]` of the held line, and `instr_valid` is 1.
- R6: A jump to a target inside the held line raises no request and no stall.
- R7: Advancing from index 7 of a held line, or from 0x7FF to 0x800, causes an automatic fill of the next line.
- R8: A one-cycle `inval` pulse discards the held line, and the next hub fetch stalls and refills. A pulse that arrives during a fill discards that fill, so a second fill follows.
- R9: `win_addr` in 0x1E0 to 0x1E7 gives `win_hit` = 1 and `win_data` = buffer entry `win_addr[2:0]`. Any other window address gives `win_hit` = 0 and `win_data` = 0.
- R10: `jmp_valid` loads `pc` from `jmp_target` on the next edge and takes priority over `adv`. `adv` has no effect while `stall` is 1.
- R11: `stall` is 1 from the cycle a hub miss is visible until the cycle after the last beat of a fill that is kept, and `pc` holds throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jmp_valid | input | 1 | Load the program counter from the jump target |
| jmp_target | input | 16 | Jump target, long address |
| adv | input | 1 | Step the program counter by one long |
| inval | input | 1 | A cached hub access elsewhere; discard the line |
| loc_addr | output | 11 | Local instruction memory address |
| loc_instr | input | 32 | Instruction read from local memory |
| hub_req | output | 1 | Line read request |
| hub_addr | output | 18 | Byte address of the requested line |
| hub_gnt | input | 1 | Request accepted by the hub |
| hub_rvalid | input | 1 | One returned long is valid |
| hub_rdata | input | 32 | Returned long |
| win_addr | input | 9 | Register window read address |
| win_hit | output | 1 | Window address falls on the line buffer |
| win_data | output | 32 | Line buffer entry at the window address |
| instr | output | 32 | Instruction at the program counter |
| instr_valid | output | 1 | `instr` may be issued |
| stall | output | 1 | Core must hold |
| pc | output | 16 | Program counter, long address |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-long line, the hub boundary at 0x800 and the window at 0x1E0.

With these values, a single step from 0x7FF to 0x800 crosses from local to hub fetch. A step from index 7 crosses a line edge after only a few instructions. Every window slot, and the addresses on either side of the window, can be probed directly.

The hub model can be given a grant delay, which exercises the request-hold rule. An invalidate can be placed in the middle of a fill's beats, which exercises the rule that a killed fill is refetched.

// File: rtl/hubx_pkg.sv
package hubx_pkg;

   typedef enum logic [1:0] {
      FL_IDLE = 2'd0,
      FL_REQ  = 2'd1,
      FL_DATA = 2'd2
   } fill_state_t;

endpackage

// File: rtl/hubx_pc.sv
module hubx_pc #(
   parameter int PC_W     = 16,
   parameter int HUB_BASE = 'h800
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            jmp_valid,
   input  logic [PC_W-1:0] jmp_target,
   input  logic            adv,
   input  logic            stall,
   output logic [PC_W-1:0] pc,
   output logic            pc_is_hub
);

   localparam logic [PC_W-1:0] HUB_LIM = PC_W'(HUB_BASE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (jmp_valid) begin
         pc <= jmp_target;
      end else if (adv && !stall) begin
         pc <= pc + 1'b1;
      end
   end

   assign pc_is_hub = (pc >= HUB_LIM);

   // R10
   jmp_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jmp_valid |=> pc == $past(jmp_target));

   // R11
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !jmp_valid) |=> $stable(pc));

endmodule

// File: rtl/hubx_fill_fsm.sv
module hubx_fill_fsm
   import hubx_pkg::*;
#(
   parameter int PC_W       = 16,
   parameter int LINE_LONGS = 8,
   localparam int IDX_W     = $clog2(LINE_LONGS),
   localparam int TAG_W     = PC_W - IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss,
   input  logic [TAG_W-1:0] pc_tag,
   input  logic             inval,
   output logic             hub_req,
   output logic [PC_W+1:0]  hub_addr,
   input  logic             hub_gnt,
   input  logic             hub_rvalid,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             fill_start,
   output logic             fill_commit,
   output logic [TAG_W-1:0] fill_tag
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE_LONGS - 1);

   fill_state_t      st;
   logic [IDX_W-1:0] beat;
   logic [TAG_W-1:0] tag_q;
   logic             kill_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= FL_IDLE;
         beat   <= '0;
         tag_q  <= '0;
         kill_q <= 1'b0;
      end else begin
         case (st)
            FL_IDLE: begin
               if (miss) begin
                  st     <= FL_REQ;
                  tag_q  <= pc_tag;
                  kill_q <= 1'b0;
               end
            end
            FL_REQ: begin
               if (inval) kill_q <= 1'b1;
               if (hub_gnt) begin
                  st   <= FL_DATA;
                  beat <= '0;
               end
            end
            FL_DATA: begin
               if (inval) kill_q <= 1'b1;
               if (hub_rvalid) begin
                  beat <= beat + 1'b1;
                  if (beat == LAST) st <= FL_IDLE;
               end
            end
            default: st <= FL_IDLE;
         endcase
      end
   end

   assign hub_req     = (st == FL_REQ);
   assign hub_addr    = {tag_q, {(IDX_W + 2){1'b0}}};
   assign wr_en       = (st == FL_DATA) && hub_rvalid;
   assign wr_idx      = beat;
   assign fill_start  = (st == FL_IDLE) && miss;
   assign fill_commit = wr_en && (beat == LAST) && !kill_q && !inval;
   assign fill_tag    = tag_q;

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hub_req && !hub_gnt) |=> (hub_req && $stable(hub_addr)));

   // R3
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hub_req && hub_gnt) |=> !hub_req);

endmodule

// File: rtl/hubx_line_buf.sv
module hubx_line_buf #(
   parameter int PC_W       = 16,
   parameter int LINE_LONGS = 8,
   parameter int DATA_W     = 32,
   localparam int IDX_W     = $clog2(LINE_LONGS),
   localparam int TAG_W     = PC_W - IDX_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [DATA_W-1:0]                  wr_data,
   input  logic                               fill_start,
   input  logic                               fill_commit,
   input  logic [TAG_W-1:0]                   fill_tag,
   input  logic                               inval,
   input  logic [TAG_W-1:0]                   rd_tag,
   output logic                               hit,
   output logic [LINE_LONGS-1:0][DATA_W-1:0]  ents
);

   logic             line_valid;
   logic [TAG_W-1:0] line_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_valid <= 1'b0;
         line_tag   <= '0;
      end else if (inval || fill_start) begin
         line_valid <= 1'b0;
      end else if (fill_commit) begin
         line_valid <= 1'b1;
         line_tag   <= fill_tag;
      end
   end

   for (genvar g = 0; g < LINE_LONGS; g++) begin : g_ent
      logic [DATA_W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            ent_q <= wr_data;
         end
      end
      assign ents[g] = ent_q;
   end

   assign hit = line_valid && (line_tag == rd_tag);

   // R3
   valid_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_valid) |-> $past(wr_en));

   // R8
   inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inval |=> !line_valid);

endmodule

// File: rtl/hubx_fetch_ctrl.sv
module hubx_fetch_ctrl #(
   parameter int PC_W       = 16,
   parameter int LINE_LONGS = 8,
   parameter int DATA_W     = 32,
   parameter int HUB_BASE   = 'h800,
   parameter int REG_AW     = 9,
   parameter int WIN_BASE   = 'h1E0,
   parameter bit WIN_EN     = 1'b1,
   localparam int IDX_W     = $clog2(LINE_LONGS),
   localparam int TAG_W     = PC_W - IDX_W,
   localparam int LOC_AW    = $clog2(HUB_BASE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              jmp_valid,
   input  logic [PC_W-1:0]   jmp_target,
   input  logic              adv,
   input  logic              inval,
   output logic [LOC_AW-1:0] loc_addr,
   input  logic [DATA_W-1:0] loc_instr,
   output logic              hub_req,
   output logic [PC_W+1:0]   hub_addr,
   input  logic              hub_gnt,
   input  logic              hub_rvalid,
   input  logic [DATA_W-1:0] hub_rdata,
   input  logic [REG_AW-1:0] win_addr,
   output logic              win_hit,
   output logic [DATA_W-1:0] win_data,
   output logic [DATA_W-1:0] instr,
   output logic              instr_valid,
   output logic              stall,
   output logic [PC_W-1:0]   pc
);

   if (LINE_LONGS < 2 || (LINE_LONGS & (LINE_LONGS - 1)) != 0) begin : g_bad_line
      $error("LINE_LONGS must be a power of two of at least 2");
   end
   if ((HUB_BASE & (HUB_BASE - 1)) != 0 || LOC_AW >= PC_W) begin : g_bad_base
      $error("HUB_BASE must be a power of two below the counter range");
   end
   if ((WIN_BASE % LINE_LONGS) != 0 || WIN_BASE + LINE_LONGS > (1 << REG_AW)) begin : g_bad_win
      $error("WIN_BASE must be line aligned inside the register space");
   end

   logic                              pc_is_hub;
   logic                              hit;
   logic                              miss;
   logic [LINE_LONGS-1:0][DATA_W-1:0] ents;
   logic                              wr_en;
   logic [IDX_W-1:0]                  wr_idx;
   logic                              fill_start;
   logic                              fill_commit;
   logic [TAG_W-1:0]                  fill_tag;

   assign miss        = pc_is_hub && !hit;
   assign stall       = miss;
   assign instr_valid = !miss;
   assign loc_addr    = pc[LOC_AW-1:0];
   assign instr       = pc_is_hub ? ents[pc[IDX_W-1:0]] : loc_instr;

   hubx_pc #(
      .PC_W     (PC_W),
      .HUB_BASE (HUB_BASE)
   ) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .jmp_valid  (jmp_valid),
      .jmp_target (jmp_target),
      .adv        (adv),
      .stall      (stall),
      .pc         (pc),
      .pc_is_hub  (pc_is_hub)
   );

   hubx_fill_fsm #(
      .PC_W       (PC_W),
      .LINE_LONGS (LINE_LONGS)
   ) u_fill (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss        (miss),
      .pc_tag      (pc[PC_W-1:IDX_W]),
      .inval       (inval),
      .hub_req     (hub_req),
      .hub_addr    (hub_addr),
      .hub_gnt     (hub_gnt),
      .hub_rvalid  (hub_rvalid),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .fill_start  (fill_start),
      .fill_commit (fill_commit),
      .fill_tag    (fill_tag)
   );

   hubx_line_buf #(
      .PC_W       (PC_W),
      .LINE_LONGS (LINE_LONGS),
      .DATA_W     (DATA_W)
   ) u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (hub_rdata),
      .fill_start  (fill_start),
      .fill_commit (fill_commit),
      .fill_tag    (fill_tag),
      .inval       (inval),
      .rd_tag      (pc[PC_W-1:IDX_W]),
      .hit         (hit),
      .ents        (ents)
   );

   if (WIN_EN) begin : g_win
      localparam logic [REG_AW-1:0] WB = REG_AW'(WIN_BASE);
      assign win_hit  = (win_addr[REG_AW-1:IDX_W] == WB[REG_AW-1:IDX_W]);
      assign win_data = win_hit ? ents[win_addr[IDX_W-1:0]] : '0;
   end else begin : g_nowin
      assign win_hit  = 1'b0;
      assign win_data = '0;
   end

   // R2
   local_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hub_req) |-> $past(pc_is_hub));

   // R11
   stall_until_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !hub_rvalid && !jmp_valid) |=> stall);

endmodule

// File: tb/hubx_fetch_ctrl_test.sv
module hubx_fetch_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        jmp_valid;
   logic [15:0] jmp_target;
   logic        adv;
   logic        inval;
   logic [10:0] loc_addr;
   logic [31:0] loc_instr;
   logic        hub_req;
   logic [17:0] hub_addr;
   logic        hub_gnt;
   logic        hub_rvalid;
   logic [31:0] hub_rdata;
   logic [8:0]  win_addr;
   logic        win_hit;
   logic [31:0] win_data;
   logic [31:0] instr;
   logic        instr_valid;
   logic        stall;
   logic [15:0] pc;

   int checks = 0;
   int failures = 0;
   int fills = 0;
   int gnt_delay = 0;
   bit req_dropped = 0;
   logic [17:0] last_addr = '0;

   always #2 clk = ~clk;

   assign loc_instr = 32'h1000_0000 | {21'd0, loc_addr};

   hubx_fetch_ctrl uut (
      .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .jmp_target(jmp_target),
      .adv(adv), .inval(inval), .loc_addr(loc_addr), .loc_instr(loc_instr),
      .hub_req(hub_req), .hub_addr(hub_addr), .hub_gnt(hub_gnt),
      .hub_rvalid(hub_rvalid), .hub_rdata(hub_rdata), .win_addr(win_addr),
      .win_hit(win_hit), .win_data(win_data), .instr(instr),
      .instr_valid(instr_valid), .stall(stall), .pc(pc)
   );

   function automatic logic [31:0] exp_long(input logic [15:0] p);
      return 32'hC0DE_0000 ^ {16'd0, p};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // hub memory model: long at address p holds exp_long(p)
   initial begin
      hub_gnt = 0; hub_rvalid = 0; hub_rdata = '0;
      forever begin
         @(negedge clk);
         if (hub_req === 1'b1) begin
            logic [15:0] base;
            fills++;
            last_addr = hub_addr;
            base = hub_addr[17:2];
            repeat (gnt_delay) begin
               @(negedge clk);
               if (hub_req !== 1'b1 || hub_addr !== last_addr) req_dropped = 1;
            end
            hub_gnt = 1;
            @(negedge clk);
            hub_gnt = 0;
            for (int b = 0; b < 8; b++) begin
               hub_rvalid = 1;
               hub_rdata  = exp_long(base + 16'(b));
               @(negedge clk);
            end
            hub_rvalid = 0;
         end
      end
   end

   task automatic wait_ready(input string req);
      int n = 0;
      while (stall === 1'b1 && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(stall === 1'b0, req, {31'd0, stall}, 32'd0);
   endtask

   task automatic do_jump(input logic [15:0] t);
      @(negedge clk);
      jmp_valid = 1; jmp_target = t;
      @(negedge clk);
      jmp_valid = 0;
   endtask

   task automatic do_adv();
      @(negedge clk);
      adv = 1;
      @(negedge clk);
      adv = 0;
   endtask

   task automatic t_reset();
      chk(pc === 16'd0, "R1 pc", {16'd0, pc}, 32'd0);
      chk(stall === 1'b0, "R1 stall", {31'd0, stall}, 32'd0);
      chk(hub_req === 1'b0, "R1 hub_req", {31'd0, hub_req}, 32'd0);
   endtask

   task automatic t_priority_local();
      @(negedge clk);
      jmp_valid = 1; jmp_target = 16'h0010; adv = 1;
      @(negedge clk);
      jmp_valid = 0; adv = 0;
      chk(pc === 16'h0010, "R10 jump over adv", {16'd0, pc}, 32'h10);
      chk(instr === 32'h1000_0010 && instr_valid === 1'b1, "R2 local instr", instr, 32'h1000_0010);
      chk(stall === 1'b0 && hub_req === 1'b0, "R2 no stall/req", {30'd0, stall, hub_req}, 32'd0);
   endtask

   task automatic t_jump_miss();
      int f0 = fills;
      do_jump(16'h0803);
      chk(stall === 1'b1, "R11 stall on miss", {31'd0, stall}, 32'd1);
      wait_ready("R11 stall released");
      chk(fills == f0 + 1, "R3 one fill", fills, f0 + 1);
      chk(last_addr === 18'h02000, "R3 line byte address", {14'd0, last_addr}, 32'h2000);
      chk(instr === exp_long(16'h0803) && instr_valid === 1'b1, "R5 instr at index 3", instr, exp_long(16'h0803));
   endtask

   task automatic t_jump_hit();
      int f0 = fills;
      do_jump(16'h0806);
      chk(stall === 1'b0, "R6 no stall on hit", {31'd0, stall}, 32'd0);
      chk(instr === exp_long(16'h0806), "R6 instr", instr, exp_long(16'h0806));
      repeat (3) @(negedge clk);
      chk(fills == f0, "R6 no request", fills, f0);
   endtask

   task automatic t_seq_refill();
      int f0 = fills;
      do_adv();
      chk(pc === 16'h0807 && instr === exp_long(16'h0807), "R5 index 7", instr, exp_long(16'h0807));
      do_adv();
      chk(stall === 1'b1, "R7 stall past line end", {31'd0, stall}, 32'd1);
      wait_ready("R7 refill done");
      chk(fills == f0 + 1 && last_addr === 18'h02020, "R7 next line address", {14'd0, last_addr}, 32'h2020);
      chk(instr === exp_long(16'h0808), "R7 instr", instr, exp_long(16'h0808));
   endtask

   task automatic t_adv_stalled();
      do_jump(16'h0900);
      adv = 1;
      repeat (3) @(negedge clk);
      adv = 0;
      chk(pc === 16'h0900, "R10 adv ignored while stalled", {16'd0, pc}, 32'h900);
      wait_ready("R10 fill");
      chk(pc === 16'h0900 && instr === exp_long(16'h0900), "R10 pc held", instr, exp_long(16'h0900));
   endtask

   task automatic t_grant_wait();
      gnt_delay = 4; req_dropped = 0;
      do_jump(16'h0A00);
      wait_ready("R4 fill");
      gnt_delay = 0;
      chk(req_dropped == 0, "R4 request held", {31'd0, req_dropped}, 32'd0);
      chk(instr === exp_long(16'h0A00), "R4 instr", instr, exp_long(16'h0A00));
   endtask

   task automatic t_inval_idle();
      int f0 = fills;
      @(negedge clk);
      inval = 1;
      @(negedge clk);
      inval = 0;
      chk(stall === 1'b1, "R8 stall after inval", {31'd0, stall}, 32'd1);
      wait_ready("R8 refill");
      chk(fills == f0 + 1, "R8 refetch", fills, f0 + 1);
      chk(instr === exp_long(16'h0A00), "R8 instr", instr, exp_long(16'h0A00));
   endtask

   task automatic t_inval_mid();
      int f0 = fills;
      int n = 0;
      do_jump(16'h0B02);
      while (hub_rvalid !== 1'b1 && n < 100) begin
         @(negedge clk);
         n++;
      end
      inval = 1;
      @(negedge clk);
      inval = 0;
      wait_ready("R8 mid fill");
      chk(fills == f0 + 2, "R8 killed fill refetched", fills, f0 + 2);
      chk(instr === exp_long(16'h0B02), "R8 instr after refetch", instr, exp_long(16'h0B02));
   endtask

   task automatic t_window();
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         win_addr = 9'h1E0 + 9'(k);
         #1;
         chk(win_hit === 1'b1 && win_data === exp_long(16'h0B00 + 16'(k)), "R9 window entry",
             win_data, exp_long(16'h0B00 + 16'(k)));
      end
      @(negedge clk);
      win_addr = 9'h1DF;
      #1;
      chk(win_hit === 1'b0 && win_data === 32'd0, "R9 below window", win_data, 32'd0);
      win_addr = 9'h1E8;
      #1;
      chk(win_hit === 1'b0 && win_data === 32'd0, "R9 above window", win_data, 32'd0);
   endtask

   task automatic t_boundary();
      int f0 = fills;
      do_jump(16'h07FF);
      chk(stall === 1'b0 && loc_addr === 11'h7FF, "R2 last local address", {21'd0, loc_addr}, 32'h7FF);
      chk(instr === 32'h1000_07FF, "R2 local instr at boundary", instr, 32'h1000_07FF);
      do_adv();
      chk(stall === 1'b1, "R7 stall at 0x800", {31'd0, stall}, 32'd1);
      wait_ready("R7 boundary fill");
      chk(fills == f0 + 1 && last_addr === 18'h02000, "R7 boundary address", {14'd0, last_addr}, 32'h2000);
      chk(instr === exp_long(16'h0800), "R5 instr at 0x800", instr, exp_long(16'h0800));
   endtask

   initial begin
      rst_n = 0; jmp_valid = 0; jmp_target = '0; adv = 0; inval = 0; win_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_priority_local();
      t_jump_miss();
      t_jump_hit();
      t_seq_refill();
      t_adv_stalled();
      t_grant_wait();
      t_inval_idle();
      t_inval_mid();
      t_window();
      t_boundary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule